// File: doc/BRIEF.md
# Interrupt Status Register with Grouped Summary Bits

This block holds the interrupt status word of an Ethernet-style DMA engine. Thirteen hardware event sources each arrive as a one-cycle pulse and latch into their own sticky status bit. Software reads the word through a small register port and clears bits by writing ones to them. A second register, the enable word, chooses which status bits take part in the summaries and which summaries reach the interrupt line.

The event sources fall into two groups. Errors and stalls form the abnormal group. Ordinary completions form the normal group. For each group, the OR of the enabled member bits sets a sticky summary bit. The abnormal summary sits at bit 15 and the normal summary at bit 16. Software clears each summary by writing a one to its position. The interrupt output is the OR of the two summaries, and each summary is gated by the enable bit at its own position.

The register port has one word-address bit: 0 selects the status word and 1 selects the enable word. Writes take effect on the clock edge. Read data is combinational from the selected address.

Top module: `irq_status_unit`

## Requirements
- R1: After synchronous reset, the status word reads 0, the enable word reads 0 and `irq_o` is 0.
- R2: A pulse on `evt_i[k]` sets status bit k, where k is one of 0..10, 13 or 14. The bit is readable one clock edge after the pulse and stays set with no further pulses.
- R3: Writing the status word (address 0) clears every status bit whose write-data bit is 1. Bits written as 0 keep their value.
- R4: If an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: Status bit 15 (abnormal summary) becomes 1 one edge after any of status bits 1, 3, 4, 5, 7, 8, 9, 10 or 13 is 1 while the enable bit at the same position is 1.
- R6: Status bit 16 (normal summary) becomes 1 one edge after any of status bits 0, 2, 6 or 14 is 1 while the enable bit at the same position is 1.
- R7: A status bit whose enable bit is 0 never sets either summary bit.
- R8: A summary bit stays 1 after its member bits are cleared or disabled. It returns to 0 only when a one is written to its position in the status word.
- R9: A summary cleared while an enabled member bit is still set reads 0 for one cycle and 1 again on the next.
- R10: `irq_o` equals (bit 15 AND enable bit 15) OR (bit 16 AND enable bit 16). It follows a change of the enable word without delay.
- R11: Status bits 11, 12 and 31:17 always read 0. Event pulses on `evt_i[11]` and `evt_i[12]`, and writes to those positions, have no effect.
- R12: The enable word (address 1) is a plain 32-bit read/write register. A write stores all 32 bits and a read returns them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Word select: 0 status, 1 enable |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected word |
| evt_i | input | 15 | One-cycle event pulses, one per status bit position 0..14 |
| irq_o | output | 1 | Interrupt request |

## Verification
Two kinds of update can land on the same status bit in one cycle. One is a hardware event pulse against a software write-one-to-clear. The other is a summary clear against a member bit that is still asserted. The bench provokes the first by driving the pulse and a write with a one at the same position on the same edge, and passes only if the bit reads back set. It provokes the second by clearing only a summary bit while its enabled member stays high. It passes only if that summary reads 0 right after the write and 1 one edge later.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

    localparam int DATA_W  = 32;
    localparam int EVT_W   = 15;
    localparam int N_GROUP = 2;

    // Summary bit positions; the interrupt gate decodes enables at the same positions.
    localparam int ABN_POS = 15;
    localparam int NRM_POS = 16;

    // Group membership over status bits 14:0.
    localparam logic [EVT_W-1:0] ABN_MASK  = 15'h27BA; // 1,3,4,5,7,8,9,10,13
    localparam logic [EVT_W-1:0] NRM_MASK  = 15'h4045; // 0,2,6,14
    localparam logic [EVT_W-1:0] IMPL_MASK = ABN_MASK | NRM_MASK;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_ENABLE = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        reg_sel_e          sel;
        logic [DATA_W-1:0] wdata;
    } reg_req_t;

    typedef enum int {
        GRP_ABN = 0,
        GRP_NRM = 1
    } grp_e;

    function automatic logic [EVT_W-1:0] group_mask(input int g);
        return (g == GRP_ABN) ? ABN_MASK : NRM_MASK;
    endfunction

    function automatic int group_pos(input int g);
        return (g == GRP_ABN) ? ABN_POS : NRM_POS;
    endfunction

endpackage

// File: rtl/isu_sticky_bank.sv
module isu_sticky_bank
    import irq_status_pkg::*;
#(
    parameter int               W    = EVT_W,
    parameter logic [W-1:0]     IMPL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i]) begin : g_impl
            logic q;
            always_ff @(posedge clk) begin
                if (rst)           q <= 1'b0;
                else if (set_i[i]) q <= 1'b1;   // set beats clear
                else if (clr_i[i]) q <= 1'b0;
            end
            assign q_o[i] = q;
        end else begin : g_none
            assign q_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/isu_summary_bit.sv
module isu_summary_bit
    import irq_status_pkg::*;
#(
    parameter int           W    = EVT_W,
    parameter logic [W-1:0] MASK = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] stat_i,
    input  logic [W-1:0] en_i,
    input  logic         clr_i,
    output logic         q_o
);
    logic hit;
    assign hit = |(stat_i & en_i & MASK);

    always_ff @(posedge clk) begin
        if (rst)        q_o <= 1'b0;
        else if (clr_i) q_o <= 1'b0;   // clear first; re-set follows next edge
        else if (hit)   q_o <= 1'b1;
    end
endmodule

// File: rtl/isu_enable_reg.sv
module isu_enable_reg
    import irq_status_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst)       q_o <= '0;
        else if (we_i) q_o <= d_i;
    end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import irq_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_i,
    input  logic              reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic [EVT_W-1:0]  evt_i,
    output logic              irq_o
);
    reg_req_t            req;
    logic                wr_stat, wr_en;
    logic [EVT_W-1:0]    stat_clr;
    logic [EVT_W-1:0]    stat_q;
    logic [DATA_W-1:0]   en_q;
    logic [N_GROUP-1:0]  sum_q;
    logic [N_GROUP-1:0]  sum_gate;
    logic [DATA_W-1:0]   status_word;

    assign req.wr    = reg_wr_i;
    assign req.sel   = reg_sel_e'(reg_addr_i);
    assign req.wdata = reg_wdata_i;

    assign wr_stat  = req.wr && (req.sel == SEL_STATUS);
    assign wr_en    = req.wr && (req.sel == SEL_ENABLE);
    assign stat_clr = wr_stat ? req.wdata[EVT_W-1:0] : '0;

    isu_sticky_bank #(.W(EVT_W), .IMPL(IMPL_MASK)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .set_i (evt_i),
        .clr_i (stat_clr),
        .q_o   (stat_q)
    );

    isu_enable_reg #(.W(DATA_W)) u_en (
        .clk  (clk),
        .rst  (rst),
        .we_i (wr_en),
        .d_i  (req.wdata),
        .q_o  (en_q)
    );

    for (genvar g = 0; g < N_GROUP; g++) begin : g_sum
        localparam int POS = group_pos(g);
        isu_summary_bit #(.W(EVT_W), .MASK(group_mask(g))) u_sum (
            .clk    (clk),
            .rst    (rst),
            .stat_i (stat_q),
            .en_i   (en_q[EVT_W-1:0]),
            .clr_i  (wr_stat && req.wdata[POS]),
            .q_o    (sum_q[g])
        );
        assign sum_gate[g] = sum_q[g] & en_q[POS];
    end

    always_comb begin
        status_word                  = '0;
        status_word[EVT_W-1:0]       = stat_q;
        status_word[ABN_POS]         = sum_q[GRP_ABN];
        status_word[NRM_POS]         = sum_q[GRP_NRM];
    end

    assign reg_rdata_o = (req.sel == SEL_ENABLE) ? en_q : status_word;
    assign irq_o       = |sum_gate;

endmodule

// File: rtl/isu_checker.sv
module isu_checker
    import irq_status_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr_i,
    input logic              reg_addr_i,
    input logic [DATA_W-1:0] reg_wdata_i,
    input logic [EVT_W-1:0]  evt_i,
    input logic              irq_o,
    input logic [EVT_W-1:0]  stat_q,
    input logic [N_GROUP-1:0] sum_q,
    input logic [DATA_W-1:0] en_q,
    input logic [DATA_W-1:0] status_word
);
    logic             wst;
    logic [EVT_W-1:0] clr_req;
    logic [EVT_W-1:0] evt_impl;
    assign wst      = reg_wr_i && (reg_addr_i == 1'b0);
    assign clr_req  = wst ? reg_wdata_i[EVT_W-1:0] : '0;
    assign evt_impl = evt_i & IMPL_MASK;

    // R2
    evt_sets_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_impl != '0) |=> ((stat_q & $past(evt_impl)) == $past(evt_impl)));

    // R3
    no_spurious_clear_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(stat_q) & ~stat_q & ~$past(clr_req)) == '0));

    // R11
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (status_word[31:17] == '0) && (status_word[12:11] == 2'b00));

    // R5
    abn_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sum_q[GRP_ABN]) |-> $past(|(stat_q & en_q[EVT_W-1:0] & ABN_MASK)));

    // R6
    nrm_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sum_q[GRP_NRM]) |-> $past(|(stat_q & en_q[EVT_W-1:0] & NRM_MASK)));

    // R8
    abn_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (sum_q[GRP_ABN] && !(wst && reg_wdata_i[ABN_POS])) |=> sum_q[GRP_ABN]);

    // R9
    nrm_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wst && reg_wdata_i[NRM_POS]) |=> !sum_q[GRP_NRM]);

    // R10
    irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (en_q[NRM_POS:ABN_POS] == 2'b00) |-> !irq_o);
endmodule

bind irq_status_unit isu_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .evt_i       (evt_i),
    .irq_o       (irq_o),
    .stat_q      (stat_q),
    .sum_q       (sum_q),
    .en_q        (en_q),
    .status_word (status_word)
);

// File: tb/tb_irq_status_unit.sv
`timescale 1ns/1ps
module tb_irq_status_unit;
    localparam logic [14:0] ABN = 15'h27BA;
    localparam logic [14:0] NRM = 15'h4045;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr_i;
    logic        reg_addr_i;
    logic [31:0] reg_wdata_i;
    logic [31:0] reg_rdata_o;
    logic [14:0] evt_i;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    irq_status_unit dut (
        .clk(clk), .rst(rst), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .evt_i(evt_i), .irq_o(irq_o)
    );

    typedef struct packed {
        logic [31:0] en;
        logic [14:0] evt;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0000, 15'h0001},
        '{32'h0001_0001, 15'h0001},
        '{32'h0000_8002, 15'h0002},
        '{32'h0000_0002, 15'h0002},
        '{32'h0001_8000, 15'h67FF},
        '{32'h0001_FFFF, 15'h1800},
        '{32'h0000_FFFF, 15'h2000},
        '{32'h0001_4000, 15'h4000},
        '{32'h0000_07FF, 15'h0400}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        tick();
        reg_wr_i = 1'b0; reg_addr_i = 1'b0; reg_wdata_i = '0;
    endtask

    task automatic pulse(input logic [14:0] e);
        evt_i = e;
        tick();
        evt_i = '0;
    endtask

    function automatic logic [31:0] exp_word(input logic [31:0] en, input logic [14:0] e);
        logic [14:0] s;
        logic ab, nm;
        s  = e & (ABN | NRM);
        ab = |(s & en[14:0] & ABN);
        nm = |(s & en[14:0] & NRM);
        return {15'b0, nm, ab, s};
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [31:0] ew;
        rst = 1'b1; reg_wr_i = 0; reg_addr_i = 0; reg_wdata_i = '0; evt_i = '0;
        repeat (4) tick();
        rst = 1'b0;
        tick();

        // R1: reset state
        reg_addr_i = 1'b0; #0; chk("R1 status", reg_rdata_o, 32'h0);
        reg_addr_i = 1'b1; #1; chk("R1 enable", reg_rdata_o, 32'h0);
        reg_addr_i = 1'b0; #1; chk("R1 irq", {31'b0, irq_o}, 32'h0);

        // Vector walk: R2 R5 R6 R7 R10 R11
        for (int i = 0; i < NV; i++) begin
            wr(1'b0, 32'hFFFF_FFFF);
            wr(1'b1, VECS[i].en);
            pulse(VECS[i].evt);
            tick();
            ew = exp_word(VECS[i].en, VECS[i].evt);
            chk("R2/R5/R6/R7/R11 status", reg_rdata_o, ew);
            chk("R10 irq", {31'b0, irq_o},
                {31'b0, (ew[15] & VECS[i].en[15]) | (ew[16] & VECS[i].en[16])});
        end

        // R3: zero write keeps bits, one clears
        wr(1'b0, 32'hFFFF_FFFF);
        wr(1'b1, 32'h0);
        pulse(15'h0005);
        wr(1'b0, 32'h0);
        chk("R3 zero write", reg_rdata_o, 32'h0000_0005);
        wr(1'b0, 32'h0000_0001);
        chk("R3 one clears", reg_rdata_o, 32'h0000_0004);

        // R4: event and clear on same bit, same cycle
        evt_i = 15'h0004; reg_wr_i = 1'b1; reg_addr_i = 1'b0; reg_wdata_i = 32'h0000_0004;
        tick();
        evt_i = '0; reg_wr_i = 1'b0; reg_wdata_i = '0;
        chk("R4 set wins", reg_rdata_o & 32'h4, 32'h4);

        // R11: writes to reserved/unimplemented bits do nothing
        wr(1'b0, 32'hFFFE_1800);
        chk("R11 reserved write", reg_rdata_o, 32'h0000_0004);

        // R9: clear summary while member remains set
        wr(1'b0, 32'hFFFF_FFFF);
        wr(1'b1, 32'h0001_0001);
        pulse(15'h0001);
        tick();
        chk("R6 normal set", reg_rdata_o, 32'h0001_0001);
        wr(1'b0, 32'h0001_0000);
        chk("R9 cleared one cycle", reg_rdata_o, 32'h0000_0001);
        tick();
        chk("R9 re-set", reg_rdata_o, 32'h0001_0001);

        // R8: summary holds after member cleared and disabled
        wr(1'b0, 32'h0000_0001);
        tick();
        chk("R8 sticky after member clear", reg_rdata_o, 32'h0001_0000);
        wr(1'b1, 32'h0001_0000);
        tick();
        chk("R8 sticky after disable", reg_rdata_o, 32'h0001_0000);
        chk("R10 irq on", {31'b0, irq_o}, 32'h1);

        // R10: enable change acts without delay
        wr(1'b1, 32'h0000_0000);
        chk("R10 irq gated off", {31'b0, irq_o}, 32'h0);
        wr(1'b0, 32'h0001_0000);
        tick();
        chk("R8 w1c summary", reg_rdata_o, 32'h0);

        // R12: enable register read/write
        wr(1'b1, 32'hDEAD_BEEF);
        reg_addr_i = 1'b1; #1;
        chk("R12 enable readback", reg_rdata_o, 32'hDEAD_BEEF);
        reg_addr_i = 1'b0;
        wr(1'b1, 32'h0);

        done = 1;
        finish_run();
    end
endmodule